// File: doc/BRIEF.md
# Dual-Ring Station with Fault Wrap

This block is one node on a pair of counter-rotating byte-stream rings. The clockwise ring (cw) enters from the left neighbour and leaves toward the right one. The counter-clockwise ring (ccw) enters from the right neighbour and leaves toward the left. Each ring carries frames as contiguous bursts of bytes. A frame opens with a 24-byte header, and the payload follows it. For every frame the station reads a destination and a source identifier from the first two header bytes. From these it copies the frame to the local receive port of that ring, passes it on, or removes it because it has come all the way round.

Each ring has a short staging pipeline of two bytes. The forward-or-strip verdict is therefore settled before the first byte of a frame leaves. There is one fault input per neighbour link. When a link is failed, traffic that would head into it is folded onto the other ring, which runs back toward the healthy side. With both links failed, the two rings are folded into each other. A fault input is taken up only while both rings are quiet, so no frame is ever split between two paths. Injecting new frames and choosing a ring to transmit on belong to a separate block.

Top module: `dual_ring_station`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every valid output is low.
- R2: A frame whose first byte carries, in its low 4 bits, a value equal to `station_id_i` appears byte for byte on the receive port of the ring it arrived on. The data, start and end marks are unchanged, and each byte appears exactly two cycles after it was presented at the input.
- R3: A frame whose second byte carries, in its low 4 bits, a value other than `station_id_i` is forwarded on the same ring's output. All bytes are unchanged, and each byte appears two cycles after its input cycle.
- R4: A frame whose second byte low nibble equals `station_id_i` is never forwarded. It is still copied locally when its first byte also names this station.
- R5: Only the low 4 bits of bytes 0 and 1 take part in the decisions. Their upper 4 bits, like all remaining header bytes, are carried through unchanged.
- R6: With only the left link failed, the ccw ring's forwarded stream leaves on the cw output, and the cw ring's forwarded stream is dropped.
- R7: With only the right link failed, the cw ring's forwarded stream leaves on the ccw output, and the ccw ring's forwarded stream is dropped.
- R8: With both links failed, the cw forwarded stream leaves on the ccw output and the ccw forwarded stream leaves on the cw output. Stripping of own frames still applies.
- R9: A fault input is taken up only at a clock edge where no byte was valid on either ring input in that cycle or in the two cycles before. A frame already in flight keeps the path it started on.
- R10: The two rings are processed independently, and frames on both can be copied and forwarded in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| station_id_i | input | ID_W | Identifier of this station |
| link_fail_left_i | input | 1 | Link to the left neighbour is failed |
| link_fail_right_i | input | 1 | Link to the right neighbour is failed |
| cw_data_i | input | 8 | Clockwise ring input byte |
| cw_valid_i | input | 1 | Clockwise input byte valid |
| cw_sof_i | input | 1 | Clockwise input first byte of frame |
| cw_eof_i | input | 1 | Clockwise input last byte of frame |
| ccw_data_i | input | 8 | Counter-clockwise ring input byte |
| ccw_valid_i | input | 1 | Counter-clockwise input byte valid |
| ccw_sof_i | input | 1 | Counter-clockwise input first byte |
| ccw_eof_i | input | 1 | Counter-clockwise input last byte |
| cw_data_o | output | 8 | Byte toward the right neighbour |
| cw_valid_o | output | 1 | Rightward byte valid |
| cw_sof_o | output | 1 | Rightward first byte of frame |
| cw_eof_o | output | 1 | Rightward last byte of frame |
| ccw_data_o | output | 8 | Byte toward the left neighbour |
| ccw_valid_o | output | 1 | Leftward byte valid |
| ccw_sof_o | output | 1 | Leftward first byte of frame |
| ccw_eof_o | output | 1 | Leftward last byte of frame |
| rx_cw_data_o | output | 8 | Local copy of clockwise frames, byte |
| rx_cw_valid_o | output | 1 | Local clockwise copy valid |
| rx_cw_sof_o | output | 1 | Local clockwise copy first byte |
| rx_cw_eof_o | output | 1 | Local clockwise copy last byte |
| rx_ccw_data_o | output | 8 | Local copy of counter-clockwise frames, byte |
| rx_ccw_valid_o | output | 1 | Local counter-clockwise copy valid |
| rx_ccw_sof_o | output | 1 | Local counter-clockwise copy first byte |
| rx_ccw_eof_o | output | 1 | Local counter-clockwise copy last byte |

## Verification
Two situations put functions into the same cycle. In the first, the strip verdict on one ring is taken while the other ring's forwarded stream is being folded onto the first ring's output. This happens under a double fault, where an own frame on cw must vanish while a ccw frame emerges on the cw output. In the second, a fault input toggles in the middle of a frame, which must not move that frame. The bench drives these cases with overlapping frames on both rings and a fault flip at a fixed byte index. Its behavioural model decides from input history alone, on every clock, which byte each of the four output ports must show. Per-port byte counts per scenario judge where each frame went.

// File: rtl/drs_pkg.sv
package drs_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              v;
    logic              sof;
    logic              eof;
    logic [BYTE_W-1:0] d;
  } beat_t;
endpackage

// File: rtl/drs_lane.sv
module drs_lane
  import drs_pkg::*;
#(
  parameter int unsigned ID_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] id_i,
  input  beat_t           in_i,
  output beat_t           fwd_o,
  output beat_t           rx_o,
  output logic            busy_o
);
  beat_t s1_q, s2_q;
  logic  fwd_q, copy_q, in_frame_q;
  logic  hdr1;

  // byte 1 at input while byte 0 sits in stage 1
  assign hdr1 = in_i.v && s1_q.v && s1_q.sof;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q       <= '0;
      s2_q       <= '0;
      fwd_q      <= 1'b0;
      copy_q     <= 1'b0;
      in_frame_q <= 1'b0;
    end else begin
      s1_q <= in_i;
      s2_q <= s1_q;
      if (hdr1) begin
        fwd_q  <= (in_i.d[ID_W-1:0] != id_i);
        copy_q <= (s1_q.d[ID_W-1:0] == id_i);
      end
      if (in_i.v) begin
        if (in_i.eof)      in_frame_q <= 1'b0;
        else if (in_i.sof) in_frame_q <= 1'b1;
      end
    end
  end

  always_comb begin
    fwd_o     = s2_q;
    fwd_o.v   = s2_q.v & fwd_q;
    fwd_o.sof = s2_q.sof & s2_q.v & fwd_q;
    fwd_o.eof = s2_q.eof & s2_q.v & fwd_q;
    rx_o      = s2_q;
    rx_o.v    = s2_q.v & copy_q;
    rx_o.sof  = s2_q.sof & s2_q.v & copy_q;
    rx_o.eof  = s2_q.eof & s2_q.v & copy_q;
  end

  assign busy_o = in_i.v | s1_q.v | s2_q.v | in_frame_q;

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o.v |-> $past(in_i.v, 2));
  p_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o.v |-> (fwd_o.d == $past(in_i.d, 2)));
  p_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_o.v |-> ($past(in_i.v, 2) && (rx_o.sof == $past(in_i.sof, 2))));
  p_strip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr1 && (in_i.d[ID_W-1:0] == id_i)) |=> !fwd_o.v);
endmodule

// File: rtl/drs_fault_latch.sv
module drs_fault_latch #(
  parameter int unsigned N_RING = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_RING-1:0] busy_i,
  input  logic              fail_l_i,
  input  logic              fail_r_i,
  output logic              wrap_l_o,
  output logic              wrap_r_o
);
  logic wrap_l_q, wrap_r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrap_l_q <= 1'b0;
      wrap_r_q <= 1'b0;
    end else if (busy_i == '0) begin
      wrap_l_q <= fail_l_i;
      wrap_r_q <= fail_r_i;
    end
  end

  assign wrap_l_o = wrap_l_q;
  assign wrap_r_o = wrap_r_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i != '0) |=> ($stable(wrap_l_q) && $stable(wrap_r_q)));
endmodule

// File: rtl/drs_wrap_mux.sv
module drs_wrap_mux
  import drs_pkg::*;
(
  input  beat_t fwd_cw_i,
  input  beat_t fwd_ccw_i,
  input  logic  wrap_l_i,
  input  logic  wrap_r_i,
  output beat_t out_cw_o,
  output beat_t out_ccw_o
);
  // rightward port: folded ccw on left fault, silent on right-only fault
  always_comb begin
    if (wrap_l_i)      out_cw_o = fwd_ccw_i;
    else if (wrap_r_i) out_cw_o = '0;
    else               out_cw_o = fwd_cw_i;

    if (wrap_r_i)      out_ccw_o = fwd_cw_i;
    else if (wrap_l_i) out_ccw_o = '0;
    else               out_ccw_o = fwd_ccw_i;
  end
endmodule

// File: rtl/dual_ring_station.sv
module dual_ring_station
  import drs_pkg::*;
#(
  parameter int unsigned ID_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   station_id_i,
  input  logic              link_fail_left_i,
  input  logic              link_fail_right_i,
  input  logic [BYTE_W-1:0] cw_data_i,
  input  logic              cw_valid_i,
  input  logic              cw_sof_i,
  input  logic              cw_eof_i,
  input  logic [BYTE_W-1:0] ccw_data_i,
  input  logic              ccw_valid_i,
  input  logic              ccw_sof_i,
  input  logic              ccw_eof_i,
  output logic [BYTE_W-1:0] cw_data_o,
  output logic              cw_valid_o,
  output logic              cw_sof_o,
  output logic              cw_eof_o,
  output logic [BYTE_W-1:0] ccw_data_o,
  output logic              ccw_valid_o,
  output logic              ccw_sof_o,
  output logic              ccw_eof_o,
  output logic [BYTE_W-1:0] rx_cw_data_o,
  output logic              rx_cw_valid_o,
  output logic              rx_cw_sof_o,
  output logic              rx_cw_eof_o,
  output logic [BYTE_W-1:0] rx_ccw_data_o,
  output logic              rx_ccw_valid_o,
  output logic              rx_ccw_sof_o,
  output logic              rx_ccw_eof_o
);
  localparam int unsigned N_RING = 2;
  localparam int unsigned CW     = 0;
  localparam int unsigned CCW    = 1;

  beat_t             in_b  [N_RING];
  beat_t             fwd_b [N_RING];
  beat_t             rx_b  [N_RING];
  logic [N_RING-1:0] busy;
  beat_t             out_cw, out_ccw;
  logic              wrap_l, wrap_r;

  assign in_b[CW]  = '{v: cw_valid_i,  sof: cw_sof_i,  eof: cw_eof_i,  d: cw_data_i};
  assign in_b[CCW] = '{v: ccw_valid_i, sof: ccw_sof_i, eof: ccw_eof_i, d: ccw_data_i};

  for (genvar g = 0; g < N_RING; g++) begin : g_lane
    drs_lane #(.ID_W(ID_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .id_i   (station_id_i),
      .in_i   (in_b[g]),
      .fwd_o  (fwd_b[g]),
      .rx_o   (rx_b[g]),
      .busy_o (busy[g])
    );
  end

  drs_fault_latch #(.N_RING(N_RING)) u_flt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy),
    .fail_l_i (link_fail_left_i),
    .fail_r_i (link_fail_right_i),
    .wrap_l_o (wrap_l),
    .wrap_r_o (wrap_r)
  );

  drs_wrap_mux u_mux (
    .fwd_cw_i  (fwd_b[CW]),
    .fwd_ccw_i (fwd_b[CCW]),
    .wrap_l_i  (wrap_l),
    .wrap_r_i  (wrap_r),
    .out_cw_o  (out_cw),
    .out_ccw_o (out_ccw)
  );

  assign cw_data_o      = out_cw.d;
  assign cw_valid_o     = out_cw.v;
  assign cw_sof_o       = out_cw.sof;
  assign cw_eof_o       = out_cw.eof;
  assign ccw_data_o     = out_ccw.d;
  assign ccw_valid_o    = out_ccw.v;
  assign ccw_sof_o      = out_ccw.sof;
  assign ccw_eof_o      = out_ccw.eof;
  assign rx_cw_data_o   = rx_b[CW].d;
  assign rx_cw_valid_o  = rx_b[CW].v;
  assign rx_cw_sof_o    = rx_b[CW].sof;
  assign rx_cw_eof_o    = rx_b[CW].eof;
  assign rx_ccw_data_o  = rx_b[CCW].d;
  assign rx_ccw_valid_o = rx_b[CCW].v;
  assign rx_ccw_sof_o   = rx_b[CCW].sof;
  assign rx_ccw_eof_o   = rx_b[CCW].eof;

  p_wrap_left_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_l && cw_valid_o) |-> $past(ccw_valid_i, 2));
  p_wrap_right_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_r && ccw_valid_o) |-> $past(cw_valid_i, 2));
endmodule

// File: tb/tb_dual_ring_station.sv
module tb_dual_ring_station;
  localparam logic [3:0] MY_ID = 4'h3;

  typedef struct packed {
    logic       v;
    logic       sof;
    logic       eof;
    logic [7:0] d;
  } mb_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fail_l = 1'b0, fail_r = 1'b0;
  logic [7:0] cw_d = '0, ccw_d = '0;
  logic cw_v = 0, cw_s = 0, cw_e = 0, ccw_v = 0, ccw_s = 0, ccw_e = 0;
  logic [7:0] o_cw_d, o_ccw_d, r_cw_d, r_ccw_d;
  logic o_cw_v, o_cw_s, o_cw_e, o_ccw_v, o_ccw_s, o_ccw_e;
  logic r_cw_v, r_cw_s, r_cw_e, r_ccw_v, r_ccw_s, r_ccw_e;

  int checks = 0, failures = 0;
  int n_ocw = 0, n_occw = 0, n_rcw = 0, n_rccw = 0;

  always #10 clk = ~clk;

  dual_ring_station #(.ID_W(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .station_id_i(MY_ID),
    .link_fail_left_i(fail_l), .link_fail_right_i(fail_r),
    .cw_data_i(cw_d), .cw_valid_i(cw_v), .cw_sof_i(cw_s), .cw_eof_i(cw_e),
    .ccw_data_i(ccw_d), .ccw_valid_i(ccw_v), .ccw_sof_i(ccw_s), .ccw_eof_i(ccw_e),
    .cw_data_o(o_cw_d), .cw_valid_o(o_cw_v), .cw_sof_o(o_cw_s), .cw_eof_o(o_cw_e),
    .ccw_data_o(o_ccw_d), .ccw_valid_o(o_ccw_v), .ccw_sof_o(o_ccw_s), .ccw_eof_o(o_ccw_e),
    .rx_cw_data_o(r_cw_d), .rx_cw_valid_o(r_cw_v), .rx_cw_sof_o(r_cw_s), .rx_cw_eof_o(r_cw_e),
    .rx_ccw_data_o(r_ccw_d), .rx_ccw_valid_o(r_ccw_v), .rx_ccw_sof_o(r_ccw_s), .rx_ccw_eof_o(r_ccw_e)
  );

  // reference model state: input history, per-frame verdicts, taken-up faults
  mb_t h0 [2];
  mb_t h1 [2];
  bit  dec_fwd [2];
  bit  dec_copy [2];
  bit  m_wl, m_wr;

  always @(posedge clk or negedge rst_n) begin
    mb_t cur [2];
    if (!rst_n) begin
      for (int r = 0; r < 2; r++) begin
        h0[r] = '0; h1[r] = '0; dec_fwd[r] = 0; dec_copy[r] = 0;
      end
      m_wl = 0; m_wr = 0;
    end else begin
      cur[0] = '{v: cw_v, sof: cw_s, eof: cw_e, d: cw_d};
      cur[1] = '{v: ccw_v, sof: ccw_s, eof: ccw_e, d: ccw_d};
      // R9: quiet for three cycles on both rings
      if (!cur[0].v && !cur[1].v && !h0[0].v && !h0[1].v && !h1[0].v && !h1[1].v) begin
        m_wl = fail_l; m_wr = fail_r;
      end
      for (int r = 0; r < 2; r++) begin
        if (cur[r].v && h0[r].v && h0[r].sof) begin
          dec_fwd[r]  = (cur[r].d[3:0] != MY_ID);
          dec_copy[r] = (h0[r].d[3:0] == MY_ID);
        end
        h1[r] = h0[r];
        h0[r] = cur[r];
      end
    end
  end

  function automatic mb_t gate(mb_t b, bit en);
    mb_t g;
    g = b;
    if (!(b.v && en)) g = '0;
    return g;
  endfunction

  task automatic cmp(string tag, string port, mb_t act, mb_t exp);
    checks++;
    if ((act.v !== exp.v) || (exp.v && (act !== exp))) begin
      failures++;
      $display("FAIL %s %s actual v=%b s=%b e=%b d=%h expected v=%b s=%b e=%b d=%h",
               tag, port, act.v, act.sof, act.eof, act.d, exp.v, exp.sof, exp.eof, exp.d);
    end
  endtask

  always @(negedge clk) begin
    mb_t f0, f1, e_ocw, e_occw;
    if (rst_n) begin
      f0 = gate(h1[0], dec_fwd[0]);
      f1 = gate(h1[1], dec_fwd[1]);
      e_ocw  = m_wl ? f1 : (m_wr ? mb_t'('0) : f0);
      e_occw = m_wr ? f0 : (m_wl ? mb_t'('0) : f1);
      cmp((m_wl || m_wr) ? "R6" : "R3", "cw_out",
          '{v: o_cw_v, sof: o_cw_s, eof: o_cw_e, d: o_cw_d}, e_ocw);
      cmp((m_wl || m_wr) ? "R6" : "R3", "ccw_out",
          '{v: o_ccw_v, sof: o_ccw_s, eof: o_ccw_e, d: o_ccw_d}, e_occw);
      cmp("R2", "rx_cw", '{v: r_cw_v, sof: r_cw_s, eof: r_cw_e, d: r_cw_d},
          gate(h1[0], dec_copy[0]));
      cmp("R2", "rx_ccw", '{v: r_ccw_v, sof: r_ccw_s, eof: r_ccw_e, d: r_ccw_d},
          gate(h1[1], dec_copy[1]));
      n_ocw  += int'(o_cw_v);
      n_occw += int'(o_ccw_v);
      n_rcw  += int'(r_cw_v);
      n_rccw += int'(r_ccw_v);
    end
  end

  task automatic clr();
    @(negedge clk);
    n_ocw = 0; n_occw = 0; n_rcw = 0; n_rccw = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_cnt(string tag, int ocw, int occw, int rcw, int rccw);
    idle(4);
    one(tag, "cw_out bytes", n_ocw, ocw);
    one(tag, "ccw_out bytes", n_occw, occw);
    one(tag, "rx_cw bytes", n_rcw, rcw);
    one(tag, "rx_ccw bytes", n_rccw, rccw);
  endtask

  task automatic send(bit ea, logic [7:0] a0, logic [7:0] a1, int la,
                      bit eb, logic [7:0] b0, logic [7:0] b1, int lb,
                      int flip_at, bit flip_val);
    int n;
    n = (la > lb) ? la : lb;
    clr();
    for (int i = 0; i < n; i++) begin
      if (i == flip_at) fail_r = flip_val;
      cw_v  = ea && (i < la);
      cw_s  = ea && (i == 0);
      cw_e  = ea && (i == la - 1);
      cw_d  = (i == 0) ? a0 : (i == 1) ? a1 : 8'(i * 7 + la);
      ccw_v = eb && (i < lb);
      ccw_s = eb && (i == 0);
      ccw_e = eb && (i == lb - 1);
      ccw_d = (i == 0) ? b0 : (i == 1) ? b1 : 8'(i * 5 + lb);
      @(negedge clk);
    end
    cw_v = 0; cw_s = 0; cw_e = 0; ccw_v = 0; ccw_s = 0; ccw_e = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    one("R1", "valids in reset", int'({o_cw_v, o_ccw_v, r_cw_v, r_ccw_v}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    one("R1", "valids after reset", int'({o_cw_v, o_ccw_v, r_cw_v, r_ccw_v}), 0);
    idle(2);

    // R2 R3: addressed here, foreign source
    send(1, 8'hA3, 8'h57, 26, 0, 8'h00, 8'h00, 0, -1, 0);
    expect_cnt("R2", 26, 0, 26, 0);
    send(1, 8'hA5, 8'h57, 26, 0, 8'h00, 8'h00, 0, -1, 0);
    expect_cnt("R3", 26, 0, 0, 0);
    // R4: own source stripped, with and without copy
    send(1, 8'hA5, 8'h53, 26, 0, 8'h00, 8'h00, 0, -1, 0);
    expect_cnt("R4", 0, 0, 0, 0);
    send(1, 8'hA3, 8'h53, 26, 0, 8'h00, 8'h00, 0, -1, 0);
    expect_cnt("R4", 0, 0, 26, 0);
    // R5: upper nibbles must not matter
    send(1, 8'h35, 8'h37, 26, 0, 8'h00, 8'h00, 0, -1, 0);
    expect_cnt("R5", 26, 0, 0, 0);
    send(1, 8'hC3, 8'h93, 26, 0, 8'h00, 8'h00, 0, -1, 0);
    expect_cnt("R5", 0, 0, 26, 0);
    // R10: both rings at once
    send(1, 8'hA3, 8'h51, 26, 1, 8'hA3, 8'h52, 30, -1, 0);
    expect_cnt("R10", 26, 30, 26, 30);

    // R7: right link failed
    fail_r = 1; idle(5);
    send(1, 8'hA5, 8'h51, 26, 1, 8'hA3, 8'h52, 28, -1, 1);
    expect_cnt("R7", 0, 26, 0, 28);
    fail_r = 0; idle(5);
    // R6: left link failed
    fail_l = 1; idle(5);
    send(1, 8'hA3, 8'h51, 26, 1, 8'hA5, 8'h52, 28, -1, 0);
    expect_cnt("R6", 28, 0, 26, 0);
    // R8: both failed, own frame on cw stripped while ccw folds onto cw
    fail_r = 1; idle(5);
    send(1, 8'hA5, 8'h53, 26, 1, 8'hA5, 8'h52, 28, -1, 1);
    expect_cnt("R8", 28, 0, 0, 0);
    send(1, 8'hA5, 8'h51, 26, 0, 8'h00, 8'h00, 0, -1, 1);
    expect_cnt("R8", 0, 26, 0, 0);
    fail_l = 0; fail_r = 0; idle(5);

    // R9: fault raised mid-frame keeps the frame on its path
    send(1, 8'hA5, 8'h51, 40, 0, 8'h00, 8'h00, 0, 10, 1);
    expect_cnt("R9", 40, 0, 0, 0);
    idle(3);
    send(1, 8'hA5, 8'h51, 26, 0, 8'h00, 8'h00, 0, -1, 1);
    expect_cnt("R9", 0, 26, 0, 0);
    fail_r = 0; idle(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule